// File: doc/BRIEF.md
# FSK Byte Transmitter with Automatic Checksum

This block turns bytes from a host into a serial bit stream for a low-rate frequency-shift-keyed data link. One bit leaves on every pulse of a bit-period strobe, and each byte is sent most significant bit first. A byte can wait in a holding register while the byte ahead of it is shifted out. This gives the host a full byte time to supply the next byte. A byte written while nothing is being sent goes straight to the shifter and leaves on the next strobe.

A level input, `sum_en`, controls a cyclic checksum. Its rising edge clears the accumulator. Every byte that enters the shifter while the level is high is folded into the checksum. When the level falls, the byte in flight completes, and then two checksum bytes follow with no gap. The checksum is the 15-bit remainder of the data divided by x^15+x^14+x^13+x^11+x^4+x^2+1, with the remainder's last bit inverted, followed by one even-parity bit.

A zero hang bit closes every transmission. One strobe later a transmit-idle event is raised. A buffer-empty event marks the start of each data byte, so the host knows when it may write the next byte. Bit-rate generation, tone synthesis and register access live outside this block.

Top module: `fsk_byte_tx`

## Requirements
- R1: After reset `ser_valid`, `empty_evt` and `idle_evt` are all 0.
- R2: A byte written while the transmitter is idle is in the shifter at once. Its bit 7 is driven on the next `bit_tick`, followed by bits 6 down to 0, one per tick.
- R3: A byte written while another is shifting is sent immediately after it, with no tick between them on which `ser_valid` is low.
- R4: `empty_evt` pulses for one clock on the tick that drives bit 7 of each data byte. `ser_valid` is high on that tick.
- R5: When `sum_en` falls, the current byte completes and 16 checksum bits follow, most significant first. These are the 15-bit remainder (last bit inverted) of the included data bits divided by x^15+x^14+x^13+x^11+x^4+x^2+1, then the even parity of all included data bits and those 15 bits.
- R6: A rising edge of `sum_en` clears the checksum. A byte that entered the shifter while `sum_en` was low is not included.
- R7: `empty_evt` does not pulse during either checksum byte.
- R8: After the last byte of a transmission, or after the checksum, a single 0 hang bit is sent with `ser_valid` high.
- R9: `idle_evt` pulses on the tick after the hang bit, only when nothing follows it. `ser_valid` is low on that tick.
- R10: On a tick with nothing to send, `ser_valid` is low and `ser_bit` keeps its previous value.
- R11: While `tx_en` is low, the shifter, the holding byte and the checksum state are discarded. From the next clock on, `ser_valid`, `empty_evt` and `idle_evt` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit enable; low clears all transmit state |
| bit_tick | input | 1 | One-clock strobe, once per bit period |
| sum_en | input | 1 | Checksum inclusion level; the falling edge appends the checksum |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte to transmit |
| ser_bit | output | 1 | Serial data bit |
| ser_valid | output | 1 | High while `ser_bit` carries a transmitted bit |
| empty_evt | output | 1 | One-clock pulse: holding register free for the next byte |
| idle_evt | output | 1 | One-clock pulse: transmission finished |

## Verification
The embedded properties assume that `bit_tick` is a single-clock pulse. They also assume that writes arrive only when the holding register is free, and that `sum_en` does not rise again before a requested checksum has started. The stimulus writes the first byte of a burst while the transmitter is idle. It writes each following byte only after the buffer-empty event of the byte ahead. It raises and lowers `sum_en` only in the byte time after such an event, and it leaves `sum_en` steady until the idle event. Tick spacing is varied between bursts so that the serial timing does not depend on one strobe period.

// File: rtl/fsk_byte_tx.sv
module fsk_byte_tx #(
  parameter int DW = 8,
  parameter int RW = 15,
  parameter logic [RW-1:0] POLY = 15'h6815
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_en,
  input  logic          bit_tick,
  input  logic          sum_en,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          ser_bit,
  output logic          ser_valid,
  output logic          empty_evt,
  output logic          idle_evt
);
  localparam int CNTW = $clog2(DW + 1);
  localparam int CHKW = RW + 1;
  localparam logic [CNTW-1:0] FULLCNT = CNTW'(DW);

  logic [DW-1:0]   sh, sh_n, hold, hold_n, lo, lo_n;
  logic [CNTW-1:0] cnt, cnt_n;
  logic [RW-1:0]   crc, crc_n, crc_w, rem_mod;
  logic            par, par_n, par_w;
  logic            isdat, isdat_n, full, full_n, endr, endr_n, end_w;
  logic            lo_pend, lo_pend_n, last, last_n, hang, hang_n, hdone, hdone_n;
  logic            bit_n, val_n, emp_n, idl_n, sum_q, direct, done_byte;
  logic [CHKW-1:0] chk;

  function automatic logic [RW-1:0] crc_step(input logic [RW-1:0] c, input logic [DW-1:0] d);
    logic [RW-1:0] r;
    r = c;
    for (int i = DW - 1; i >= 0; i--)
      r = (r[RW-1] ^ d[i]) ? ((r << 1) ^ POLY) : (r << 1);
    return r;
  endfunction

  assign crc_w   = (sum_en && !sum_q) ? '0 : crc;
  assign par_w   = (sum_en && !sum_q) ? 1'b0 : par;
  assign end_w   = endr || (!sum_en && sum_q);
  assign rem_mod = crc_w ^ RW'(1);
  assign chk     = {rem_mod, par_w ^ (^rem_mod)};

  always_comb begin
    sh_n = sh; cnt_n = cnt; isdat_n = isdat; hold_n = hold; full_n = full;
    crc_n = crc_w; par_n = par_w; endr_n = end_w; lo_n = lo; lo_pend_n = lo_pend;
    last_n = last; hang_n = hang; hdone_n = hdone; bit_n = ser_bit; val_n = ser_valid;
    emp_n = 1'b0; idl_n = 1'b0; direct = 1'b0; done_byte = 1'b0;
    if (bit_tick) begin
      if (cnt != '0) begin
        bit_n = sh[DW-1]; val_n = 1'b1; sh_n = sh << 1; cnt_n = cnt - 1'b1; hdone_n = 1'b0;
        emp_n = (cnt == FULLCNT) && isdat && !end_w;
        done_byte = (cnt == CNTW'(1));
      end else if (hang) begin
        bit_n = 1'b0; val_n = 1'b1; hang_n = 1'b0; hdone_n = 1'b1;
      end else begin
        val_n = 1'b0; idl_n = hdone; hdone_n = 1'b0;
      end
    end
    if (cnt_n == '0 && !hang_n) begin
      if (last) begin
        hang_n = 1'b1; last_n = 1'b0;
      end else if (lo_pend) begin
        sh_n = lo; cnt_n = FULLCNT; isdat_n = 1'b0; lo_pend_n = 1'b0; last_n = 1'b1;
      end else if (end_w) begin
        sh_n = chk[CHKW-1 -: DW]; lo_n = chk[DW-1:0]; lo_pend_n = 1'b1;
        endr_n = 1'b0; cnt_n = FULLCNT; isdat_n = 1'b0;
      end else if (full) begin
        sh_n = hold; full_n = 1'b0; cnt_n = FULLCNT; isdat_n = 1'b1;
        if (sum_en) begin crc_n = crc_step(crc_w, hold); par_n = par_w ^ (^hold); end
      end else if (wr_en) begin
        direct = 1'b1; sh_n = wr_data; cnt_n = FULLCNT; isdat_n = 1'b1;
        if (sum_en) begin crc_n = crc_step(crc_w, wr_data); par_n = par_w ^ (^wr_data); end
      end else if (done_byte) begin
        hang_n = 1'b1;
      end
    end
    if (wr_en && !direct) begin hold_n = wr_data; full_n = 1'b1; end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sum_q <= 1'b0; ser_bit <= 1'b0;
    end else begin
      sum_q <= sum_en;
      if (tx_en) ser_bit <= bit_n;
    end
    if (!rst_n || !tx_en) begin
      sh <= '0; cnt <= '0; isdat <= 1'b0; hold <= '0; full <= 1'b0; crc <= '0; par <= 1'b0;
      endr <= 1'b0; lo <= '0; lo_pend <= 1'b0; last <= 1'b0; hang <= 1'b0; hdone <= 1'b0;
      ser_valid <= 1'b0; empty_evt <= 1'b0; idle_evt <= 1'b0;
    end else begin
      sh <= sh_n; cnt <= cnt_n; isdat <= isdat_n; hold <= hold_n; full <= full_n;
      crc <= crc_n; par <= par_n; endr <= endr_n; lo <= lo_n; lo_pend <= lo_pend_n;
      last <= last_n; hang <= hang_n; hdone <= hdone_n;
      ser_valid <= val_n; empty_evt <= emp_n; idle_evt <= idl_n;
    end
  end

  AST_EVT_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n) (empty_evt || idle_evt) |-> $past(bit_tick)); // R4
  AST_EMPTY_WITH_BIT: assert property (@(posedge clk) disable iff (!rst_n) empty_evt |-> ser_valid); // R4
  AST_IDLE_NO_BIT: assert property (@(posedge clk) disable iff (!rst_n) idle_evt |-> !ser_valid && !empty_evt); // R9
  AST_HOLD_LAST_BIT: assert property (@(posedge clk) disable iff (!rst_n) !ser_valid |-> $stable(ser_bit)); // R10
  AST_HANG_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n) ($past(tx_en) && $past(bit_tick) && $past(cnt) == '0 && $past(hang)) |-> ser_valid && !ser_bit); // R8
  AST_DISABLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !$past(tx_en) |-> !ser_valid && !empty_evt && !idle_evt); // R11
  AST_NO_EMPTY_IN_SUM: assert property (@(posedge clk) disable iff (!rst_n) (lo_pend || last) |-> !empty_evt); // R7
endmodule

// File: tb/sim_fsk_byte_tx.sv
module sim_fsk_byte_tx;
  localparam int CLK_NS = 10;

  logic clk = 1'b0, rst_n = 1'b0, tx_en = 1'b0, bit_tick = 1'b0, sum_en = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic ser_bit, ser_valid, empty_evt, idle_evt;

  int checks = 0, errors = 0, ev_cnt = 0, idle_cnt = 0, tick_div = 4, tcnt = 0;
  bit exp_q[$];
  logic [7:0] bq[$];
  bit burst_on = 1'b0, quiet = 1'b0, last_bit = 1'b0;

  fsk_byte_tx u0 (.clk(clk), .rst_n(rst_n), .tx_en(tx_en), .bit_tick(bit_tick), .sum_en(sum_en),
                  .wr_en(wr_en), .wr_data(wr_data), .ser_bit(ser_bit), .ser_valid(ser_valid),
                  .empty_evt(empty_evt), .idle_evt(idle_evt));

  always #(CLK_NS/2) clk = ~clk;

  always @(negedge clk) begin
    if (tcnt >= tick_div - 1) begin tcnt = 0; bit_tick = 1'b1; end
    else begin tcnt = tcnt + 1; bit_tick = 1'b0; end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] chk16(input logic [7:0] q[$]);
    logic [15:0] r;
    logic [14:0] rem;
    bit p;
    r = '0; p = 1'b0;
    foreach (q[i])
      for (int k = 7; k >= 0; k--) begin
        p = p ^ q[i][k];
        r = {r[14:0], q[i][k]};
        if (r[15]) r = r ^ 16'hE815;
      end
    for (int k = 0; k < 15; k++) begin
      r = {r[14:0], 1'b0};
      if (r[15]) r = r ^ 16'hE815;
    end
    rem = r[14:0];
    rem[0] = ~rem[0];
    p = p ^ (^rem);
    return {rem, p};
  endfunction

  // monitor / scoreboard
  always @(posedge clk) begin
    #1;
    if (rst_n && bit_tick) begin
      if (quiet) begin
        check(!ser_valid && !empty_evt && !idle_evt, "R11", "output while disabled",
              {ser_valid, empty_evt, idle_evt}, 0);
      end else begin
        if (ser_valid) begin
          if (exp_q.size() == 0) check(1'b0, "R2", "unexpected bit", ser_bit, -1);
          else begin
            bit e;
            e = exp_q.pop_front();
            check(ser_bit === e, "R2 R5 R8", "serial bit", ser_bit, e);
          end
          last_bit = ser_bit;
        end else begin
          check(ser_bit === last_bit, "R10", "held bit", ser_bit, last_bit);
          if (burst_on && !idle_evt) check(1'b0, "R3", "gap in burst", 0, 1);
        end
        if (empty_evt) begin
          ev_cnt++;
          check(ser_valid, "R4", "empty event without bit", ser_valid, 1);
        end
        if (idle_evt) begin
          idle_cnt++;
          check(burst_on && exp_q.size() == 0 && !ser_valid, "R9", "idle event timing", exp_q.size(), 0);
          burst_on = 1'b0;
        end
      end
    end
  end

  task automatic write_byte(input logic [7:0] b);
    @(negedge clk);
    wr_data = b; wr_en = 1'b1;
    for (int k = 7; k >= 0; k--) exp_q.push_back(b[k]);
    @(negedge clk);
    wr_en = 1'b0; burst_on = 1'b1;
  endtask

  task automatic send_burst(input bit use_sum, input int skip);
    int ev0, id0;
    logic [7:0] cs[$];
    logic [15:0] c;
    ev0 = ev_cnt; id0 = idle_cnt;
    for (int i = 0; i < bq.size(); i++) begin
      if (i > 0) wait (ev_cnt >= ev0 + i);
      if (use_sum && i == skip) begin @(negedge clk); sum_en = 1'b1; end
      write_byte(bq[i]);
      if (use_sum && i >= skip) cs.push_back(bq[i]);
    end
    if (use_sum) begin
      wait (ev_cnt >= ev0 + bq.size());
      @(negedge clk);
      sum_en = 1'b0;
      c = chk16(cs);
      for (int k = 15; k >= 0; k--) exp_q.push_back(c[k]);
    end
    exp_q.push_back(1'b0); // R8 hang bit
    wait (idle_cnt >= id0 + 1);
    check(ev_cnt - ev0 == bq.size(), "R4 R7", "empty event count", ev_cnt - ev0, bq.size());
    check(exp_q.size() == 0, "R8", "bits left over", exp_q.size(), 0);
    repeat (3 * tick_div) @(negedge clk);
    check(idle_cnt == id0 + 1, "R9", "idle event count", idle_cnt - id0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual %0d expected %0d", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!ser_valid && !empty_evt && !idle_evt, "R1", "reset outputs", {ser_valid, empty_evt, idle_evt}, 0);
    tx_en = 1'b1;
    repeat (4 * tick_div) @(negedge clk);
    check(idle_cnt == 0 && ev_cnt == 0, "R10", "no events while empty", idle_cnt + ev_cnt, 0);

    bq.delete(); bq.push_back(8'hA5);
    send_burst(1'b0, 0);                       // R2 single byte
    bq.delete(); bq.push_back(8'h81); bq.push_back(8'h00); bq.push_back(8'hFF);
    send_burst(1'b0, 0);                       // R3 back to back
    bq.delete(); bq.push_back(8'h12); bq.push_back(8'h34);
    send_burst(1'b1, 0);                       // R5 checksum
    tick_div = 7;
    bq.delete(); bq.push_back(8'hDE); bq.push_back(8'hAD); bq.push_back(8'hBE);
    send_burst(1'b1, 0);                       // R6 fresh accumulator
    bq.delete(); bq.push_back(8'h00);
    send_burst(1'b1, 0);                       // R5 inverted bit on zero data
    tick_div = 5;
    bq.delete(); bq.push_back(8'h5A); bq.push_back(8'hC3); bq.push_back(8'h0F);
    send_burst(1'b1, 1);                       // R6 first byte excluded

    // R11 disable mid-transmission
    @(negedge clk); sum_en = 1'b1;
    write_byte(8'h55);
    wait (ev_cnt > 0 && empty_evt == 1'b0);
    write_byte(8'h66);
    repeat (3 * tick_div) @(negedge clk);
    tx_en = 1'b0; quiet = 1'b1;
    @(posedge clk); #1;
    check(!ser_valid && !empty_evt && !idle_evt, "R11", "cleared after disable", ser_valid, 0);
    repeat (20) @(negedge clk);
    sum_en = 1'b0;
    exp_q.delete(); burst_on = 1'b0;
    @(negedge clk);
    quiet = 1'b0; tx_en = 1'b1;
    bq.delete(); bq.push_back(8'h3C);
    send_burst(1'b0, 0);                       // R11 held byte discarded

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule